// File: doc/BRIEF.md
# Triggered Serial ADC Capture Unit

This block takes the serial bit stream of an analog-to-digital converter, gathers each group of eight bits into one parallel sample, and records a window of 1024 consecutive samples in an on-chip two-port memory. Recording starts only when the incoming signal crosses a threshold level set by the host, in the direction the host selects. The host can also start a recording directly, without waiting for a crossing.

A host on a 16-bit addressed register bus uses the block in four steps:

1. Program the level and the edge direction.
2. Arm the unit.
3. Poll a status word until the window is complete.
4. Read the samples back. Each 8-bit sample is returned zero-extended in a 16-bit word.

Register map:

- Bus address bit 11 set selects the capture memory. The lower ten address bits give the sample index.
- With bit 11 clear, the two lowest address bits select a register:
  - index 0: control
  - index 1: level
  - index 2: status

Top module: `adc_capture_top`

## Requirements
- R1: Serial bits are taken on cycles with `bit_en` high, most significant bit first. The cycle with both `bit_en` and `bit_frame` high carries the last (least significant) bit and completes one 8-bit sample.
- R2: After reset, the status word reads 0, the level register reads 0, and the control register reads 0.
- R3: Writing control bit 0 (arm) clears the done flag and the write address. It sets status bit 0 (waiting). While waiting, samples are compared against the trigger but not stored. Status bits are: bit 0 waiting, bit 1 capturing, bit 2 done. At most one of them is set.
- R4: With control bit 2 (falling) clear, the trigger fires on a sample that is at or above the level when the previous sample was below it. The first sample after arming has no previous sample and never fires the trigger.
- R5: With control bit 2 set, the trigger fires on a sample below the level when the previous sample was at or above it.
- R6: The sample that fires the trigger is stored at index 0. Each following sample is stored at the next index.
- R7: After index 1023 is written, capture stops and status bit 2 (done) is set. Further samples change no memory entry.
- R8: Writing control bit 1 (force) while waiting starts capture at once, with no level comparison. The next sample goes to index 0. A force written while not waiting has no effect.
- R9: A read request returns data on `bus_rdata` one cycle later. Memory reads return the sample in bits 7:0 and zeros in bits 15:8.
- R10: The level register (8 bits, index 1) and the falling bit (control bit 2) read back as written. Control bits 0 and 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Serial bit valid this cycle |
| bit_in | input | 1 | Serial data bit |
| bit_frame | input | 1 | Marks the last bit of a sample |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Bus address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after request |

## Verification
Random sample streams are run against random levels in both edge directions. These runs separate a correct crossing test from one that fires on level alone or ignores the previous sample.

Directed prefixes cover several cases:

- A sample exactly equal to the level on a rising crossing, which exposes a wrong comparison (strict versus inclusive).
- A falling run that meets the level without going below it.
- A first sample after arming that is already past the level.

A rising run with level zero can never fire. It shows that waiting stores nothing until a force is written. A force written after completion, and extra samples after the 1024th, show that a finished window stays frozen.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_WAIT = 2'd1,
    CS_CAPT = 2'd2,
    CS_DONE = 2'd3
  } cap_state_e;

  localparam logic [1:0] RIDX_CTRL   = 2'd0;
  localparam logic [1:0] RIDX_LEVEL  = 2'd1;
  localparam logic [1:0] RIDX_STATUS = 2'd2;

  localparam int CB_ARM   = 0;
  localparam int CB_FORCE = 1;
  localparam int CB_FALL  = 2;

endpackage

// File: rtl/adc_cap_deser.sv
module adc_cap_deser #(
  parameter int SMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             bit_frame,
  output logic             smp_vld,
  output logic [SMP_W-1:0] smp
);

  logic [SMP_W-1:0] sh_q, sh_d;
  logic [SMP_W-1:0] smp_d;
  logic             vld_d;
  logic             smp_en;

  always_comb begin
    sh_d   = sh_q;
    smp_d  = smp;
    smp_en = bit_en & bit_frame;
    vld_d  = smp_en;
    if (bit_en) begin
      sh_d = {sh_q[SMP_W-2:0], bit_in};
    end
    if (smp_en) begin
      smp_d = {sh_q[SMP_W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      smp     <= '0;
      smp_vld <= 1'b0;
    end else begin
      if (bit_en) sh_q <= sh_d;
      if (smp_en) smp  <= smp_d;
      smp_vld <= vld_d;
    end
  end

endmodule

// File: rtl/adc_cap_trig.sv
module adc_cap_trig #(
  parameter int SMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp,
  input  logic [SMP_W-1:0] level,
  input  logic             falling,
  input  logic             clr_hist,
  output logic             hit
);

  logic [SMP_W-1:0] prev_q;
  logic             prev_ok_q;
  logic             prev_ok_d;
  logic             prev_en;
  logic             prev_lo, cur_lo;

  always_comb begin
    prev_lo = (prev_q < level);
    cur_lo  = (smp < level);
    if (falling) begin
      hit = smp_vld & prev_ok_q & ~prev_lo & cur_lo;
    end else begin
      hit = smp_vld & prev_ok_q & prev_lo & ~cur_lo;
    end
    prev_en   = smp_vld & ~clr_hist;
    prev_ok_d = clr_hist ? 1'b0 : (smp_vld ? 1'b1 : prev_ok_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else begin
      if (prev_en) prev_q <= smp;
      prev_ok_q <= prev_ok_d;
    end
  end

endmodule

// File: rtl/adc_cap_mem.sv
module adc_cap_mem #(
  parameter int SMP_W = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [SMP_W-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [SMP_W-1:0] rdata
);

  logic [SMP_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          force_go,
  input  logic          smp_vld,
  input  logic          hit,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          st_wait,
  output logic          st_capt,
  output logic          st_done
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  cap_state_e    st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    we     = 1'b0;
    if (arm) begin
      st_d   = CS_WAIT;
      addr_d = '0;
    end else begin
      unique case (st_q)
        CS_WAIT: begin
          if (hit) begin
            we     = 1'b1;
            addr_d = addr_q + 1'b1;
            st_d   = CS_CAPT;
          end else if (force_go) begin
            st_d = CS_CAPT;
          end
        end
        CS_CAPT: begin
          if (smp_vld) begin
            we = 1'b1;
            if (addr_q == LAST) begin
              st_d = CS_DONE;
            end else begin
              addr_d = addr_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CS_IDLE;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  assign waddr   = addr_q;
  assign st_wait = (st_q == CS_WAIT);
  assign st_capt = (st_q == CS_CAPT);
  assign st_done = (st_q == CS_DONE);

endmodule

// File: rtl/adc_capture_top.sv
module adc_capture_top
  import adc_cap_pkg::*;
#(
  parameter int SMP_W   = 8,
  parameter int DEPTH   = 1024,
  parameter int BUS_W   = 16,
  parameter int BUS_AW  = 12,
  localparam int AW     = $clog2(DEPTH),
  localparam int MEMSEL = BUS_AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  input  logic              bit_frame,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);

  logic             smp_vld;
  logic [SMP_W-1:0] smp;
  logic             hit;
  logic             mem_we;
  logic [AW-1:0]    mem_waddr;
  logic [SMP_W-1:0] mem_q;
  logic             st_wait, st_capt, st_done;

  logic [SMP_W-1:0] level_q, level_d;
  logic             fall_q, fall_d;
  logic             reg_wr, ctrl_wr, level_wr;
  logic             arm_cmd, force_cmd;
  logic             rd_req, rd_mem;
  logic             rd_mem_q;
  logic [BUS_W-1:0] rd_reg_q, rd_reg_d;

  adc_cap_deser #(.SMP_W(SMP_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .bit_frame(bit_frame), .smp_vld(smp_vld), .smp(smp)
  );

  adc_cap_trig #(.SMP_W(SMP_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
    .level(level_q), .falling(fall_q), .clr_hist(arm_cmd), .hit(hit)
  );

  adc_cap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm_cmd), .force_go(force_cmd),
    .smp_vld(smp_vld), .hit(hit), .we(mem_we), .waddr(mem_waddr),
    .st_wait(st_wait), .st_capt(st_capt), .st_done(st_done)
  );

  adc_cap_mem #(.SMP_W(SMP_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(smp),
    .re(rd_mem), .raddr(bus_addr[AW-1:0]), .rdata(mem_q)
  );

  always_comb begin
    reg_wr    = bus_sel & bus_wr & ~bus_addr[MEMSEL];
    ctrl_wr   = reg_wr & (bus_addr[1:0] == RIDX_CTRL);
    level_wr  = reg_wr & (bus_addr[1:0] == RIDX_LEVEL);
    arm_cmd   = ctrl_wr & bus_wdata[CB_ARM];
    force_cmd = ctrl_wr & bus_wdata[CB_FORCE];
    fall_d    = ctrl_wr ? bus_wdata[CB_FALL] : fall_q;
    level_d   = level_wr ? bus_wdata[SMP_W-1:0] : level_q;
    rd_req    = bus_sel & ~bus_wr;
    rd_mem    = rd_req & bus_addr[MEMSEL];
    rd_reg_d  = '0;
    if (rd_req & ~bus_addr[MEMSEL]) begin
      unique case (bus_addr[1:0])
        RIDX_CTRL:   rd_reg_d[CB_FALL] = fall_q;
        RIDX_LEVEL:  rd_reg_d[SMP_W-1:0] = level_q;
        RIDX_STATUS: rd_reg_d[2:0] = {st_done, st_capt, st_wait};
        default:     rd_reg_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      fall_q   <= 1'b0;
      rd_mem_q <= 1'b0;
      rd_reg_q <= '0;
    end else begin
      level_q  <= level_d;
      fall_q   <= fall_d;
      rd_mem_q <= rd_mem;
      rd_reg_q <= rd_reg_d;
    end
  end

  assign bus_rdata = rd_mem_q ? {{(BUS_W-SMP_W){1'b0}}, mem_q} : rd_reg_q;

endmodule

// File: rtl/adc_cap_checker.sv
module adc_cap_checker #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          we,
  input logic [AW-1:0] waddr,
  input logic          smp_vld,
  input logic          st_wait,
  input logic          st_capt,
  input logic          st_done
);

  p_state_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_wait, st_capt, st_done}));

  p_arm_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (st_wait && !st_done));

  p_no_store_outside_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (st_wait || st_capt));

  p_write_has_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> smp_vld);

  p_trigger_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && st_wait) |-> (waddr == '0));

  p_stop_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && st_capt && (waddr == '1) && !arm) |=> st_done);

  p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_done && !arm) |=> st_done);

endmodule

bind adc_capture_top adc_cap_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm_cmd), .we(mem_we), .waddr(mem_waddr),
  .smp_vld(smp_vld), .st_wait(st_wait), .st_capt(st_capt), .st_done(st_done)
);

// File: tb/sim_adc_capture_top.sv
module sim_adc_capture_top;

  logic        clk;
  logic        rst_n;
  logic        bit_en, bit_in, bit_frame;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  int n_chk;
  int n_bad;
  int cyc;

  logic [7:0] exp_mem [1024];
  int         m_state;
  int         m_addr;
  logic [7:0] m_prev;
  bit         m_prev_ok;
  logic [7:0] m_level;
  bit         m_fall;

  adc_capture_top u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .bit_frame(bit_frame), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
        summary();
      end
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] exp_status();
    case (m_state)
      1: return 16'h0001;
      2: return 16'h0002;
      3: return 16'h0004;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit model_hit(input logic [7:0] s);
    if (!m_prev_ok) return 1'b0;
    if (m_fall) return (m_prev >= m_level) && (s < m_level);
    return (m_prev < m_level) && (s >= m_level);
  endfunction

  task automatic model_sample(input logic [7:0] s);
    if (m_state == 1 && model_hit(s)) begin
      exp_mem[0] = s;
      m_addr = 1;
      m_state = 2;
    end else if (m_state == 2) begin
      exp_mem[m_addr] = s;
      if (m_addr == 1023) m_state = 3;
      else m_addr++;
    end
    m_prev = s;
    m_prev_ok = 1'b1;
  endtask

  task automatic send_sample(input logic [7:0] s);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      if (($urandom % 6) == 0) begin
        bit_en = 1'b0; bit_in = 1'($urandom); bit_frame = 1'($urandom);
        @(negedge clk);
      end
      bit_en = 1'b1; bit_in = s[i]; bit_frame = (i == 0);
    end
    @(negedge clk);
    bit_en = 1'b0; bit_frame = 1'b0;
    model_sample(s);
  endtask

  task automatic check_status(input string req);
    logic [15:0] d;
    bus_read(12'h002, d);
    check(req, d, exp_status());
  endtask

  task automatic arm(input logic [7:0] lvl, input bit fall);
    bus_write(12'h001, {8'h00, lvl});
    bus_write(12'h000, {13'd0, fall, 2'b01});
    m_level = lvl; m_fall = fall;
    m_state = 1; m_addr = 0; m_prev_ok = 1'b0;
  endtask

  task automatic force_go();
    bus_write(12'h000, {13'd0, m_fall, 2'b10});
    if (m_state == 1) m_state = 2;
  endtask

  task automatic finish_capture();
    int n;
    n = 0;
    while (m_state != 3) begin
      send_sample(8'($urandom));
      n++;
      if (n == 300 && m_state == 1) force_go();
    end
    check_status("R7 done after 1024 stored");
    for (int k = 0; k < 3; k++) send_sample(8'($urandom));
    check_status("R7 stays done");
  endtask

  task automatic verify_mem(input string req);
    logic [15:0] d;
    for (int k = 0; k < 1024; k++) begin
      bus_read(12'h800 | 12'(k), d);
      check(req, d, {8'h00, exp_mem[k]});
    end
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EED_0042));
    n_chk = 0; n_bad = 0;
    bit_en = 0; bit_in = 0; bit_frame = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    m_state = 0; m_addr = 0; m_prev = '0; m_prev_ok = 0; m_level = '0; m_fall = 0;
    for (int k = 0; k < 1024; k++) exp_mem[k] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values
    check_status("R2 status after reset");
    bus_read(12'h001, d); check("R2 level after reset", d, 16'h0000);
    bus_read(12'h000, d); check("R2 ctrl after reset", d, 16'h0000);

    // R8 force while idle is ignored
    bus_write(12'h000, 16'h0002);
    check_status("R8 force ignored when idle");

    // R10 register readback
    arm(8'h5A, 1'b1);
    bus_read(12'h001, d); check("R10 level readback", d, 16'h005A);
    bus_read(12'h000, d); check("R10 falling readback", d, 16'h0004);
    check_status("R3 waiting after arm");

    // R8 + R1: forced capture, directed MSB-first samples
    force_go();
    check_status("R8 capturing after force");
    send_sample(8'hA5); send_sample(8'h01); send_sample(8'h80);
    bus_read(12'h800, d); check("R1 R9 sample at index 0", d, 16'h00A5);
    bus_read(12'h802, d); check("R1 sample at index 2", d, 16'h0080);
    finish_capture();
    verify_mem("R6 R9 forced capture contents");

    // R8 force after done is ignored
    force_go();
    check_status("R8 force ignored when done");

    // R4 rising, equal-level crossing; first sample cannot fire
    arm(8'h80, 1'b0);
    send_sample(8'h90);
    check_status("R4 first sample no trigger");
    send_sample(8'h10); send_sample(8'h7F);
    check_status("R4 below level no trigger");
    send_sample(8'h80);
    check_status("R4 trigger on equal");
    bus_read(12'h800, d); check("R6 trigger sample at 0", d, 16'h0080);
    finish_capture();
    verify_mem("R4 R6 rising capture contents");

    // R5 falling: meeting level is not a crossing
    arm(8'h40, 1'b1);
    send_sample(8'h30); send_sample(8'h50); send_sample(8'h40);
    check_status("R5 equal not falling");
    send_sample(8'h3F);
    check_status("R5 falling trigger");
    bus_read(12'h800, d); check("R5 trigger sample at 0", d, 16'h003F);
    finish_capture();
    verify_mem("R5 falling capture contents");

    // R3 waiting stores nothing (rising, level 0 never fires)
    arm(8'h00, 1'b0);
    for (int k = 0; k < 20; k++) send_sample(8'($urandom));
    check_status("R3 still waiting");
    bus_read(12'h800, d); check("R3 index 0 untouched", d, {8'h00, exp_mem[0]});
    bus_read(12'h813, d); check("R3 index 19 untouched", d, {8'h00, exp_mem[19]});
    force_go();
    finish_capture();

    // random runs
    for (int r = 0; r < 3; r++) begin
      arm(8'(1 + ($urandom % 254)), 1'($urandom));
      finish_capture();
      verify_mem("R4 R5 R6 random capture contents");
    end

    summary();
  end

endmodule